// File: doc/BRIEF.md
# Serial-Input Edge Event Detector

This block sits behind the input side of a serial pin expander. Each time the shift-chain scan finishes, it receives a fresh snapshot of up to 64 remote input pins. It compares that snapshot with the one taken before and records the edges that software has asked for. The pins are grouped in banks of eight. Each pin carries a two-bit sensitivity code that chooses no detection, rising edges, falling edges or both.

A detected edge sets a sticky status bit. Software clears the bit by writing a one to it. The block drives a single interrupt line that stays high while any status bit in any bank is set. Software reaches the sensitivity codes and the status bits through a simple register write port and a combinational read port.

When the scan is disabled, the stored reference snapshot is discarded. The first snapshot taken after the scan is enabled again only becomes the new reference, so stale data cannot produce events.

Top module: `serial_edge_events`

## Requirements
- R1: After reset, every sensitivity register and every status register reads 0 and `irq` is low.
- R2: The sensitivity register of bank b sits at address 0x10+2b and is 16 bits wide. Pin p of the bank uses bits [2p+1:2p]. A write stores all 16 bits, and a read returns them. Input index k maps to bank k/8 and bit k%8.
- R3: With code 01, a pin that is 0 in one completed sample and 1 in the next sets its status bit. A 1-to-0 change does not set it.
- R4: With code 10, a 1-to-0 change between consecutive samples sets the status bit. A 0-to-1 change does not set it.
- R5: Code 11 sets the status bit on a change in either direction. Code 00 never sets it.
- R6: While `scan_en` is low, samples are ignored and the reference is dropped. The first completed sample after `scan_en` rises only loads the reference and never raises an event.
- R7: The status register of bank b is at address 0x20+b and reads as {8'h00, status}. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. A set bit otherwise stays set.
- R8: If an edge and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly while at least one status bit of any bank is set.
- R10: Writing 00 to a pin's code stops new events for that pin but leaves its status bit as it is.
- R11: A status bit is set only in a cycle with a completed sample (`scan_done`) in which the pin's value differs from the reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Scan running; low discards the reference |
| scan_done | input | 1 | One-cycle strobe: `scan_bits` holds a completed sample |
| scan_bits | input | NUM_BANKS*8 | Sampled input pins, index k = bank k/8, bit k%8 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data (status uses bits 7:0) |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 16 | Read data for `rd_addr`; 0 for unmapped addresses |
| irq | output | 1 | Combined event interrupt |

## Verification
Some properties are checked on every cycle by assertions:
- a status bit is never lost without a matching clear write (R7);
- a simultaneous edge and clear leaves the bit set (R8);
- no status bit rises outside a compare cycle (R11);
- no status bit rises on the reference-loading sample or while the scan is disabled (R6);
- `irq` only falls after a register write (R9).

Other behaviour can only be shown by the bench's scenarios:
- that each sensitivity code selects the right edge direction;
- that an index maps to the right bank and bit;
- that code 00 leaves old status alone;
- that writing 0 to a status bit changes nothing.

// File: rtl/sgev_pkg.sv
package sgev_pkg;
    localparam int BANK_PINS = 8;
    localparam int CFG_W     = 2 * BANK_PINS;
    localparam int CFG_BASE  = 16;   // 0x10, two bytes per bank
    localparam int STS_BASE  = 32;   // 0x20, one byte per bank

    typedef enum logic [1:0] {
        SENSE_OFF  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

    typedef struct packed {
        logic [CFG_W-1:0]     cfg;
        logic [BANK_PINS-1:0] sts;
    } bank_state_t;
endpackage

// File: rtl/sgev_bank.sv
module sgev_bank
    import sgev_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 sts_we,
    input  logic [CFG_W-1:0]     wdata,
    input  logic                 cmp_en,
    input  logic [BANK_PINS-1:0] prev_bits,
    input  logic [BANK_PINS-1:0] cur_bits,
    output logic [CFG_W-1:0]     cfg_o,
    output logic [BANK_PINS-1:0] sts_o
);
    bank_state_t          state_d, state_q;
    logic [BANK_PINS-1:0] evt;
    logic [BANK_PINS-1:0] clr_mask;

    always_comb begin
        clr_mask = sts_we ? wdata[BANK_PINS-1:0] : '0;
        for (int i = 0; i < BANK_PINS; i++) begin
            sense_e s;
            logic   want_rise, want_fall;
            s         = sense_e'(state_q.cfg[2*i +: 2]);
            want_rise = (s == SENSE_RISE) || (s == SENSE_BOTH);
            want_fall = (s == SENSE_FALL) || (s == SENSE_BOTH);
            evt[i]    = cmp_en && ((want_rise && !prev_bits[i] && cur_bits[i]) ||
                                   (want_fall && prev_bits[i] && !cur_bits[i]));
        end
        state_d     = state_q;
        if (cfg_we) state_d.cfg = wdata;
        // a new edge wins over a clear of the same bit
        state_d.sts = (state_q.sts & ~clr_mask) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cfg_o = state_q.cfg;
    assign sts_o = state_q.sts;

    // R7: set bits not targeted by a clear survive
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((state_q.sts & $past(state_q.sts & ~clr_mask)) == $past(state_q.sts & ~clr_mask)));

    // R8: edge and clear in the same cycle leaves the bit set
    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & clr_mask) != '0) |=> ((state_q.sts & $past(evt & clr_mask)) == $past(evt & clr_mask)));

    // R11: no status bit rises outside a compare cycle
    p_no_spont_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> ((state_q.sts & ~$past(state_q.sts)) == '0));
endmodule

// File: rtl/serial_edge_events.sv
module serial_edge_events
    import sgev_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ADDR_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           scan_en,
    input  logic                           scan_done,
    input  logic [NUM_BANKS*BANK_PINS-1:0] scan_bits,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CFG_W-1:0]               wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [CFG_W-1:0]               rd_data,
    output logic                           irq
);
    localparam int NUM_IN = NUM_BANKS * BANK_PINS;

    typedef struct packed {
        logic [NUM_IN-1:0] ref_bits;
        logic              ref_ok;
    } ref_state_t;

    ref_state_t           ref_d, ref_q;
    logic                 cmp_en;
    logic [CFG_W-1:0]     cfg_b [NUM_BANKS];
    logic [BANK_PINS-1:0] sts_b [NUM_BANKS];
    logic [NUM_IN-1:0]    sts_all;

    always_comb begin
        ref_d = ref_q;
        if (!scan_en) begin
            ref_d.ref_ok = 1'b0;
        end else if (scan_done) begin
            ref_d.ref_bits = scan_bits;
            ref_d.ref_ok   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= ref_d;
    end

    assign cmp_en = scan_en && scan_done && ref_q.ref_ok;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_BASE + 2*b);
        localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_BASE + b);
        sgev_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (wr_en && (wr_addr == CFG_A)),
            .sts_we    (wr_en && (wr_addr == STS_A)),
            .wdata     (wr_data),
            .cmp_en    (cmp_en),
            .prev_bits (ref_q.ref_bits[b*BANK_PINS +: BANK_PINS]),
            .cur_bits  (scan_bits[b*BANK_PINS +: BANK_PINS]),
            .cfg_o     (cfg_b[b]),
            .sts_o     (sts_b[b])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            sts_all[b*BANK_PINS +: BANK_PINS] = sts_b[b];
            if (rd_addr == ADDR_W'(CFG_BASE + 2*b)) rd_data = cfg_b[b];
            if (rd_addr == ADDR_W'(STS_BASE + b))   rd_data = {{(CFG_W-BANK_PINS){1'b0}}, sts_b[b]};
        end
    end

    assign irq = |sts_all;

    // R6: the reference-loading sample raises nothing
    p_first_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && scan_done && !ref_q.ref_ok) |=> ((sts_all & ~$past(sts_all)) == '0));

    // R6: no events while the scan is disabled
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> ((sts_all & ~$past(sts_all)) == '0));

    // R9: the interrupt only drops after a clearing write
    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en));
endmodule

// File: tb/sim_serial_edge_events.sv
`timescale 1ns/100ps
module sim_serial_edge_events;
    localparam int K_WR = 0, K_SMP = 1, K_RD = 2, K_IRQ = 3;
    localparam int NV = 32;

    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  addr;
        logic [63:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{2'(K_WR),  8'h10, 64'h1,    16'h0,    8'd2},  // R2 pin0 rising
        '{2'(K_RD),  8'h10, 64'h0,    16'h0001, 8'd2},  // R2 readback
        '{2'(K_WR),  8'h12, 64'h0008, 16'h0,    8'd2},  // R2 pin9 falling
        '{2'(K_RD),  8'h12, 64'h0,    16'h0008, 8'd2},  // R2
        '{2'(K_WR),  8'h1E, 64'hC000, 16'h0,    8'd2},  // R2 pin63 both
        '{2'(K_SMP), 8'h00, 64'h0,    16'h0,    8'd6},  // R6 reference only
        '{2'(K_RD),  8'h20, 64'h0,    16'h0000, 8'd6},  // R6
        '{2'(K_SMP), 8'h00, 64'h8000_0000_0000_0203, 16'h0, 8'd3},
        '{2'(K_RD),  8'h20, 64'h0,    16'h0001, 8'd3},  // R3 pin0 rose, pin1 code 00 (R5)
        '{2'(K_RD),  8'h21, 64'h0,    16'h0000, 8'd4},  // R4 rise ignored
        '{2'(K_RD),  8'h27, 64'h0,    16'h0080, 8'd5},  // R5 both, rising
        '{2'(K_IRQ), 8'h00, 64'h0,    16'h0001, 8'd9},  // R9
        '{2'(K_WR),  8'h27, 64'h0080, 16'h0,    8'd7},  // R7 clear
        '{2'(K_RD),  8'h27, 64'h0,    16'h0000, 8'd7},  // R7
        '{2'(K_SMP), 8'h00, 64'h0,    16'h0,    8'd4},
        '{2'(K_RD),  8'h21, 64'h0,    16'h0002, 8'd4},  // R4 pin9 fell
        '{2'(K_RD),  8'h27, 64'h0,    16'h0080, 8'd5},  // R5 both, falling
        '{2'(K_RD),  8'h20, 64'h0,    16'h0001, 8'd3},  // R3 fall ignored, bit stays
        '{2'(K_WR),  8'h20, 64'h0000, 16'h0,    8'd7},  // R7 write 0
        '{2'(K_RD),  8'h20, 64'h0,    16'h0001, 8'd7},  // R7 unchanged
        '{2'(K_WR),  8'h10, 64'h0000, 16'h0,    8'd10}, // R10 code 00
        '{2'(K_RD),  8'h20, 64'h0,    16'h0001, 8'd10}, // R10 kept
        '{2'(K_SMP), 8'h00, 64'h1,    16'h0,    8'd10},
        '{2'(K_RD),  8'h20, 64'h0,    16'h0001, 8'd10}, // R10 no new event
        '{2'(K_WR),  8'h20, 64'h00FF, 16'h0,    8'd7},
        '{2'(K_WR),  8'h21, 64'h00FF, 16'h0,    8'd7},
        '{2'(K_WR),  8'h27, 64'h00FF, 16'h0,    8'd7},
        '{2'(K_IRQ), 8'h00, 64'h0,    16'h0000, 8'd9},  // R9 all clear
        '{2'(K_RD),  8'h1E, 64'h0,    16'hC000, 8'd2},  // R2 config kept
        '{2'(K_SMP), 8'h00, 64'h1,    16'h0,    8'd11}, // R11 no change
        '{2'(K_RD),  8'h27, 64'h0,    16'h0000, 8'd11}, // R11
        '{2'(K_RD),  8'h21, 64'h0,    16'h0000, 8'd11}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_en = 1'b0, scan_done = 1'b0, wr_en = 1'b0;
    logic [63:0] scan_bits = '0;
    logic [7:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    serial_edge_events u0 (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_done(scan_done),
        .scan_bits(scan_bits), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic step(input logic we, input logic [7:0] a, input logic [15:0] d,
                        input logic sv, input logic [63:0] s);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; scan_done = sv; scan_bits = s;
        @(negedge clk);
        wr_en = 1'b0; scan_done = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [15:0] e, input int req);
        rd_addr = a;
        #1;
        n_chk++;
        if (rd_data !== e) begin
            n_bad++;
            $display("FAIL R%0d addr %02h: got %04h expected %04h", req, a, rd_data, e);
        end
    endtask

    task automatic chk_irq(input logic e, input int req);
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL R%0d irq: got %b expected %b", req, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_rd(8'h10, 16'h0, 1);
        chk_rd(8'h27, 16'h0, 1);
        chk_irq(1'b0, 1);
        scan_en = 1'b1;

        for (int i = 0; i < NV; i++) begin
            case (int'(TBL[i].kind))
                K_WR:    step(1'b1, TBL[i].addr, TBL[i].data[15:0], 1'b0, '0);
                K_SMP:   step(1'b0, 8'h00, 16'h0, 1'b1, TBL[i].data);
                K_RD:    chk_rd(TBL[i].addr, TBL[i].exp, int'(TBL[i].req));
                default: chk_irq(TBL[i].exp[0], int'(TBL[i].req));
            endcase
        end

        // R6: disabled samples ignored, first sample after enable is reference only
        step(1'b1, 8'h10, 16'h0003, 1'b0, '0);
        @(negedge clk); scan_en = 1'b0;
        step(1'b0, 8'h00, 16'h0, 1'b1, 64'h1);
        chk_rd(8'h20, 16'h0000, 6);
        @(negedge clk); scan_en = 1'b1;
        step(1'b0, 8'h00, 16'h0, 1'b1, 64'h0);
        chk_rd(8'h20, 16'h0000, 6);
        step(1'b0, 8'h00, 16'h0, 1'b1, 64'h1);
        chk_rd(8'h20, 16'h0001, 5);   // R5 rise with code 11
        // R8: falling edge and clear in the same cycle
        step(1'b1, 8'h20, 16'h0001, 1'b1, 64'h0);
        chk_rd(8'h20, 16'h0001, 8);
        chk_irq(1'b1, 8);
        step(1'b1, 8'h20, 16'h0001, 1'b0, '0);
        chk_rd(8'h20, 16'h0000, 7);
        chk_irq(1'b0, 9);
        chk_rd(8'h55, 16'h0000, 2);   // R2 unmapped address reads zero
        finish_run();
    end
endmodule